// File: doc/BRIEF.md
# Pipeline Control Word Stager

This block travels alongside a five-stage in-order integer pipeline. Its stages are fetch, decode, execute, memory and writeback. The decoder produces every control bit for the instruction in decode, and this block latches those bits into three groups. The execute group holds the ALU operation code, the ALU operand-source select and the destination-register select. The memory group holds the branch flag, the load enable and the store enable. The writeback group holds the load-result select and the register-write enable. Each group is carried only as far as the stage that consumes it, so the execute group is dropped when an instruction leaves execute. Each stage register also carries a valid bit.

The block owns the program counter and the decode-slot valid bit. It turns three requests into stage enables and a next-PC choice. A stall request from the hazard logic holds the PC and the decode slot and sends an all-zero bubble into execute. A taken branch resolved in the memory stage squashes the younger instructions and redirects fetch to the branch target. An exception raised by a valid instruction in execute kills that instruction and all younger ones, saves its PC, and redirects fetch to a fixed handler address. Instructions that are already in memory or writeback drain normally.

Top module: `pipe_ctl_stager`

## Requirements
- R1: While reset is asserted, every stage valid bit and every staged control output is 0, `pc` equals RESET_PC, `epc` is 0, and `npc_sel` is 0.
- R2: When the decode slot is valid and there is no stall or redirect, the decoder's execute-group bits appear on `ex_alu_op`, `ex_alu_src` and `ex_dst_sel` on the next cycle with `ex_valid` set. When the decode slot is invalid, an all-zero word with `ex_valid` clear enters execute instead.
- R3: On every cycle that is not a redirect, the memory group and its valid bit move from execute to the memory outputs one cycle later. The writeback group and its valid bit always move from memory to the writeback outputs one cycle later.
- R4: When `stall_req` is high and there is no redirect, `pc_en` and `ifid_en` are 0. On the next cycle `pc` and `id_valid` are unchanged, execute holds an all-zero word with `ex_valid` clear, and memory and writeback still advance.
- R5: When there is no stall and no redirect, `npc_sel` is 0 (sequential) and `pc` advances by 4 on the next cycle.
- R6: A taken branch is `mem_valid & mem_branch & br_cond`. It sets `npc_sel` to 1 and loads `br_target` into `pc`. The decode slot is cleared, and the instructions entering execute and memory arrive with their valid, load, store and register-write bits all 0.
- R7: An exception is `ex_valid & exc_req`. It sets `npc_sel` to 2, loads HANDLER_PC into `pc`, saves the excepting instruction's PC into `epc`, and kills the decode, execute and memory entries in the same way as R6. The writeback stage still receives the older instruction.
- R8: `exc_req` has no effect while `ex_valid` is 0. `epc` changes only on a recognised exception.
- R9: When a redirect (R6 or R7) and `stall_req` occur in the same cycle, the redirect wins: `pc_en` is 1 and no bubble is inserted.
- R10: When an exception and a taken branch occur in the same cycle, `npc_sel` is 2 and `pc` becomes HANDLER_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_alu_op | input | 4 | Decoder ALU operation for the instruction in decode |
| dec_alu_src | input | 1 | Decoder ALU operand-source select |
| dec_dst_sel | input | 1 | Decoder destination-register select |
| dec_branch | input | 1 | Decoder conditional-branch flag |
| dec_mem_rd | input | 1 | Decoder load enable |
| dec_mem_wr | input | 1 | Decoder store enable |
| dec_mem_to_reg | input | 1 | Decoder load-result select |
| dec_reg_wr | input | 1 | Decoder register-write enable |
| stall_req | input | 1 | Hazard-logic stall request |
| br_cond | input | 1 | Branch condition for the instruction in memory |
| br_target | input | PC_W | Branch target for the instruction in memory |
| exc_req | input | 1 | Exception raised by the instruction in execute |
| pc | output | PC_W | Fetch program counter |
| pc_en | output | 1 | PC update enable |
| ifid_en | output | 1 | Decode-slot load enable |
| npc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 handler |
| id_valid | output | 1 | Decode slot holds a live instruction |
| ex_valid | output | 1 | Execute slot valid |
| ex_alu_op | output | 4 | Staged ALU operation |
| ex_alu_src | output | 1 | Staged ALU operand-source select |
| ex_dst_sel | output | 1 | Staged destination select |
| mem_valid | output | 1 | Memory slot valid |
| mem_branch | output | 1 | Staged branch flag |
| mem_rd | output | 1 | Staged load enable |
| mem_wr | output | 1 | Staged store enable |
| wb_valid | output | 1 | Writeback slot valid |
| wb_mem_to_reg | output | 1 | Staged load-result select |
| wb_reg_wr | output | 1 | Staged register-write enable |
| epc | output | PC_W | PC of the last excepting instruction |

## Verification
A corrupted valid bit or control group shows up at the stage outputs within one cycle. A missed squash, for example, leaves `mem_wr` or `wb_reg_wr` high on the cycle after the redirect. It then reaches the next stage one cycle later, so a single bad bit is caught two to three times as it moves down the pipe. A wrong PC or decode-slot state appears on `pc` on the next cycle. Three cycles later the same fault also appears at `epc`, because the PC travelling with an instruction is only visible when that instruction raises an exception. The exception phases exist to expose that hidden path.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ALU_OP_W   = 4;
  localparam int INSN_BYTES = 4;

  typedef struct packed {
    logic [ALU_OP_W-1:0] alu_op;
    logic                alu_src;
    logic                dst_sel;
  } ex_grp_t;

  typedef struct packed {
    logic branch;
    logic rd;
    logic wr;
  } mem_grp_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_grp_t;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_EXC = 2'd2
  } npc_sel_e;

  function automatic mem_grp_t kill_mem(mem_grp_t g);
    mem_grp_t r = g;
    r.rd = 1'b0;
    r.wr = 1'b0;
    return r;
  endfunction

  function automatic wb_grp_t kill_wb(wb_grp_t g);
    wb_grp_t r = g;
    r.reg_wr = 1'b0;
    return r;
  endfunction

  function automatic npc_sel_e pick_npc(logic exc, logic br);
    if (exc)     return NPC_EXC;
    else if (br) return NPC_BR;
    else         return NPC_SEQ;
  endfunction
endpackage

// File: rtl/pcs_redirect.sv
module pcs_redirect
  import pcs_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_valid,
  input  logic            mem_branch,
  input  logic            br_cond,
  input  logic            ex_valid,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            exc_req,
  input  logic            stall_req,
  output logic            br_take,
  output logic            exc_take,
  output logic            flush,
  output logic            stall_eff,
  output npc_sel_e        npc_sel,
  output logic [PC_W-1:0] epc
);
  always_comb begin
    br_take   = mem_valid & mem_branch & br_cond;
    exc_take  = ex_valid & exc_req;
    flush     = br_take | exc_take;
    stall_eff = stall_req & ~flush;
    npc_sel   = pick_npc(exc_take, br_take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        epc <= '0;
    else if (exc_take) epc <= ex_pc;
  end

  // R10
  exc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && ex_valid && mem_valid && mem_branch && br_cond) |-> npc_sel == NPC_EXC);

  // R7
  epc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && ex_valid) |=> epc == $past(ex_pc));

  // R8
  epc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && ex_valid) |=> $stable(epc));
endmodule

// File: rtl/pcs_fetch.sv
module pcs_fetch
  import pcs_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            stall_eff,
  input  npc_sel_e        npc_sel,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pc,
  output logic            pc_en,
  output logic            ifid_en,
  output logic            id_valid,
  output logic [PC_W-1:0] id_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  function automatic logic [PC_W-1:0] pc_step(logic [PC_W-1:0] p);
    return p + STEP;
  endfunction

  always_comb begin
    pc_en   = ~stall_eff;
    ifid_en = ~stall_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= RESET_PC;
      id_valid <= 1'b0;
      id_pc    <= '0;
    end else begin
      case (npc_sel)
        NPC_EXC: pc <= HANDLER_PC;
        NPC_BR:  pc <= br_target;
        default: if (pc_en) pc <= pc_step(pc);
      endcase
      if (flush) begin
        id_valid <= 1'b0;
      end else if (ifid_en) begin
        id_valid <= 1'b1;
        id_pc    <= pc;
      end
    end
  end

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_en |=> $stable(pc) && $stable(id_valid));

  // R7
  handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npc_sel == NPC_EXC |=> pc == HANDLER_PC && !id_valid);

  // R6
  br_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npc_sel == NPC_BR |=> pc == $past(br_target) && !id_valid);
endmodule

// File: rtl/pcs_stage_regs.sv
module pcs_stage_regs
  import pcs_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [PC_W-1:0] id_pc,
  input  ex_grp_t         dec_ex,
  input  mem_grp_t        dec_mem,
  input  wb_grp_t         dec_wb,
  input  logic            stall_eff,
  input  logic            flush,
  output logic            ex_valid,
  output logic [PC_W-1:0] ex_pc,
  output ex_grp_t         ex_g,
  output logic            mem_valid,
  output mem_grp_t        mem_g,
  output logic            wb_valid,
  output wb_grp_t         wb_g
);
  ex_grp_t  src_ex;
  mem_grp_t src_mem;
  wb_grp_t  src_wb;
  mem_grp_t ex_mg;
  wb_grp_t  ex_wg;
  wb_grp_t  mem_wg;

  always_comb begin
    src_ex  = id_valid ? dec_ex  : '0;
    src_mem = id_valid ? dec_mem : '0;
    src_wb  = id_valid ? dec_wb  : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid  <= 1'b0;
      ex_pc     <= '0;
      ex_g      <= '0;
      ex_mg     <= '0;
      ex_wg     <= '0;
      mem_valid <= 1'b0;
      mem_g     <= '0;
      mem_wg    <= '0;
      wb_valid  <= 1'b0;
      wb_g      <= '0;
    end else begin
      if (flush) begin
        ex_valid <= 1'b0;
        ex_pc    <= id_pc;
        ex_g     <= src_ex;
        ex_mg    <= kill_mem(src_mem);
        ex_wg    <= kill_wb(src_wb);
      end else if (stall_eff) begin
        ex_valid <= 1'b0;
        ex_pc    <= '0;
        ex_g     <= '0;
        ex_mg    <= '0;
        ex_wg    <= '0;
      end else begin
        ex_valid <= id_valid;
        ex_pc    <= id_pc;
        ex_g     <= src_ex;
        ex_mg    <= src_mem;
        ex_wg    <= src_wb;
      end
      mem_valid <= ex_valid & ~flush;
      mem_g     <= flush ? kill_mem(ex_mg) : ex_mg;
      mem_wg    <= flush ? kill_wb(ex_wg)  : ex_wg;
      wb_valid  <= mem_valid;
      wb_g      <= mem_wg;
    end
  end

  // R4
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_eff |=> !ex_valid && ex_g == '0 && ex_mg == '0 && ex_wg == '0);

  // R6
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ex_valid && !mem_valid && !ex_mg.rd && !ex_mg.wr && !ex_wg.reg_wr
              && !mem_g.rd && !mem_g.wr && !mem_wg.reg_wr);

  // R2
  ex_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall_eff && !flush) |=> ex_valid);

  // R3
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> wb_valid);
endmodule

// File: rtl/pipe_ctl_stager.sv
module pipe_ctl_stager
  import pcs_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ALU_OP_W-1:0] dec_alu_op,
  input  logic                dec_alu_src,
  input  logic                dec_dst_sel,
  input  logic                dec_branch,
  input  logic                dec_mem_rd,
  input  logic                dec_mem_wr,
  input  logic                dec_mem_to_reg,
  input  logic                dec_reg_wr,
  input  logic                stall_req,
  input  logic                br_cond,
  input  logic [PC_W-1:0]     br_target,
  input  logic                exc_req,
  output logic [PC_W-1:0]     pc,
  output logic                pc_en,
  output logic                ifid_en,
  output logic [1:0]          npc_sel,
  output logic                id_valid,
  output logic                ex_valid,
  output logic [ALU_OP_W-1:0] ex_alu_op,
  output logic                ex_alu_src,
  output logic                ex_dst_sel,
  output logic                mem_valid,
  output logic                mem_branch,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                wb_valid,
  output logic                wb_mem_to_reg,
  output logic                wb_reg_wr,
  output logic [PC_W-1:0]     epc
);
  ex_grp_t   dec_ex, ex_g;
  mem_grp_t  dec_mem, mem_g;
  wb_grp_t   dec_wb, wb_g;
  logic      br_take, exc_take, flush, stall_eff;
  npc_sel_e  sel;
  logic [PC_W-1:0] id_pc, ex_pc;

  always_comb begin
    dec_ex  = '{alu_op: dec_alu_op, alu_src: dec_alu_src, dst_sel: dec_dst_sel};
    dec_mem = '{branch: dec_branch, rd: dec_mem_rd, wr: dec_mem_wr};
    dec_wb  = '{mem_to_reg: dec_mem_to_reg, reg_wr: dec_reg_wr};
  end

  pcs_redirect #(.PC_W(PC_W)) redir_i (
    .clk(clk), .rst_n(rst_n),
    .mem_valid(mem_valid), .mem_branch(mem_g.branch), .br_cond(br_cond),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .exc_req(exc_req), .stall_req(stall_req),
    .br_take(br_take), .exc_take(exc_take), .flush(flush), .stall_eff(stall_eff),
    .npc_sel(sel), .epc(epc)
  );

  pcs_fetch #(.PC_W(PC_W), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)) fetch_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .stall_eff(stall_eff),
    .npc_sel(sel), .br_target(br_target),
    .pc(pc), .pc_en(pc_en), .ifid_en(ifid_en), .id_valid(id_valid), .id_pc(id_pc)
  );

  pcs_stage_regs #(.PC_W(PC_W)) stages_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_pc(id_pc),
    .dec_ex(dec_ex), .dec_mem(dec_mem), .dec_wb(dec_wb),
    .stall_eff(stall_eff), .flush(flush),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_g(ex_g),
    .mem_valid(mem_valid), .mem_g(mem_g),
    .wb_valid(wb_valid), .wb_g(wb_g)
  );

  always_comb begin
    npc_sel       = sel;
    ex_alu_op     = ex_g.alu_op;
    ex_alu_src    = ex_g.alu_src;
    ex_dst_sel    = ex_g.dst_sel;
    mem_branch    = mem_g.branch;
    mem_rd        = mem_g.rd;
    mem_wr        = mem_g.wr;
    wb_mem_to_reg = wb_g.mem_to_reg;
    wb_reg_wr     = wb_g.reg_wr;
  end

  // R9
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && (br_take || exc_take)) |-> pc_en && ifid_en);
endmodule

// File: tb/pipe_ctl_stager_tb_top.sv
`timescale 1ns/1ps
module pipe_ctl_stager_tb_top;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] HND_PC = 32'h0000_0180;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [3:0] dec_alu_op;
  logic dec_alu_src, dec_dst_sel, dec_branch, dec_mem_rd, dec_mem_wr, dec_mem_to_reg, dec_reg_wr;
  logic stall_req, br_cond, exc_req;
  logic [31:0] br_target;
  logic [31:0] pc, epc;
  logic pc_en, ifid_en, id_valid, ex_valid, ex_alu_src, ex_dst_sel;
  logic [1:0] npc_sel;
  logic [3:0] ex_alu_op;
  logic mem_valid, mem_branch, mem_rd, mem_wr, wb_valid, wb_mem_to_reg, wb_reg_wr;

  pipe_ctl_stager #(.PC_W(32), .RESET_PC(RST_PC), .HANDLER_PC(HND_PC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_alu_op(dec_alu_op), .dec_alu_src(dec_alu_src), .dec_dst_sel(dec_dst_sel),
    .dec_branch(dec_branch), .dec_mem_rd(dec_mem_rd), .dec_mem_wr(dec_mem_wr),
    .dec_mem_to_reg(dec_mem_to_reg), .dec_reg_wr(dec_reg_wr),
    .stall_req(stall_req), .br_cond(br_cond), .br_target(br_target), .exc_req(exc_req),
    .pc(pc), .pc_en(pc_en), .ifid_en(ifid_en), .npc_sel(npc_sel), .id_valid(id_valid),
    .ex_valid(ex_valid), .ex_alu_op(ex_alu_op), .ex_alu_src(ex_alu_src), .ex_dst_sel(ex_dst_sel),
    .mem_valid(mem_valid), .mem_branch(mem_branch), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_valid(wb_valid), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr), .epc(epc)
  );

  typedef struct {
    logic v; logic [31:0] a; logic known;
    logic [3:0] alu; logic src, dst, br, rd, wr, m2r, rw;
  } slot_t;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int n_both = 0;

  logic [31:0] m_pc, m_idpc, m_epc;
  logic m_idv;
  slot_t m_ex, m_mem, m_wb;

  function automatic slot_t blank();
    slot_t s;
    s.v = 0; s.a = 0; s.known = 1; s.alu = 0;
    s.src = 0; s.dst = 0; s.br = 0; s.rd = 0; s.wr = 0; s.m2r = 0; s.rw = 0;
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic model_reset();
    m_pc = RST_PC; m_idpc = 0; m_epc = 0; m_idv = 0;
    m_ex = blank(); m_mem = blank(); m_wb = blank();
  endtask

  task automatic compare_stages(input string tag_ex, input string tag_mem, input string tag_wb);
    chk(tag_ex, "ex_valid", 32'(ex_valid), 32'(m_ex.v));
    if (m_ex.known) begin
      chk(tag_ex, "ex_alu_op", 32'(ex_alu_op), 32'(m_ex.alu));
      chk(tag_ex, "ex_alu_src", 32'(ex_alu_src), 32'(m_ex.src));
      chk(tag_ex, "ex_dst_sel", 32'(ex_dst_sel), 32'(m_ex.dst));
    end
    chk(tag_mem, "mem_valid", 32'(mem_valid), 32'(m_mem.v));
    chk(tag_mem, "mem_rd", 32'(mem_rd), 32'(m_mem.rd));
    chk(tag_mem, "mem_wr", 32'(mem_wr), 32'(m_mem.wr));
    if (m_mem.known) chk(tag_mem, "mem_branch", 32'(mem_branch), 32'(m_mem.br));
    chk(tag_wb, "wb_valid", 32'(wb_valid), 32'(m_wb.v));
    chk(tag_wb, "wb_reg_wr", 32'(wb_reg_wr), 32'(m_wb.rw));
    if (m_wb.known) chk(tag_wb, "wb_mem_to_reg", 32'(wb_mem_to_reg), 32'(m_wb.m2r));
  endtask

  task automatic drive(input int ps, input int pb, input int pc_cond, input int pe);
    dec_alu_op     = 4'($urandom_range(15, 0));
    dec_alu_src    = 1'($urandom_range(1, 0));
    dec_dst_sel    = 1'($urandom_range(1, 0));
    dec_branch     = ($urandom_range(99, 0) < pb);
    dec_mem_rd     = 1'($urandom_range(1, 0));
    dec_mem_wr     = 1'($urandom_range(1, 0));
    dec_mem_to_reg = 1'($urandom_range(1, 0));
    dec_reg_wr     = 1'($urandom_range(1, 0));
    stall_req      = ($urandom_range(99, 0) < ps);
    br_cond        = ($urandom_range(99, 0) < pc_cond);
    br_target      = {18'h0, 12'($urandom_range(4095, 0)), 2'b00};
    exc_req        = ($urandom_range(99, 0) < pe);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0;
    drive(0, 0, 0, 0);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, RST_PC);
    chk("R1", "epc", epc, 0);
    chk("R1", "npc_sel", 32'(npc_sel), 0);
    chk("R1", "id_valid", 32'(id_valid), 0);
    chk("R1", "ctl", {13'h0, ex_valid, ex_alu_op, ex_alu_src, ex_dst_sel, mem_valid, mem_branch,
                      mem_rd, mem_wr, wb_valid, wb_mem_to_reg, wb_reg_wr, 6'h0}, 0);
    rst_n = 1;

    for (int c = 0; c < 700; c++) begin
      logic brt, exct, flush, stall_eff;
      logic [1:0] esel;
      string tag;
      slot_t s, n_ex, n_mem, n_wb;
      logic [31:0] n_pc, n_idpc, n_epc;
      logic n_idv;
      if (c != 0) @(negedge clk);
      if      (c < 30)  drive(0, 0, 0, 0);
      else if (c < 100) drive(35, 0, 0, 0);
      else if (c < 200) drive(0, 30, 70, 0);
      else if (c < 280) drive(0, 0, 0, 15);
      else              drive(20, 30, 60, 25);
      #1;
      brt       = m_mem.v && m_mem.br && br_cond;
      exct      = m_ex.v && exc_req;
      flush     = brt || exct;
      stall_eff = stall_req && !flush;
      esel      = exct ? 2'd2 : (brt ? 2'd1 : 2'd0);
      if (exct && brt) begin tag = "R10"; n_both++; end
      else if (exct) tag = "R7";
      else if (brt) tag = "R6";
      else if (exc_req) tag = "R8";
      else if (stall_req) tag = "R4";
      else tag = "R5";
      if (stall_req && flush) tag = {tag, "/R9"};

      // outputs from state after the last edge plus current inputs
      chk(tag, "npc_sel", 32'(npc_sel), 32'(esel));
      chk(tag, "pc_en", 32'(pc_en), 32'(!stall_eff));
      chk(tag, "ifid_en", 32'(ifid_en), 32'(!stall_eff));
      chk("R5", "pc", pc, m_pc);
      chk("R4", "id_valid", 32'(id_valid), 32'(m_idv));
      chk("R8", "epc", epc, m_epc);
      compare_stages("R2", "R3", "R3");

      // next state
      n_pc   = exct ? HND_PC : (brt ? br_target : (stall_eff ? m_pc : m_pc + 32'd4));
      n_idv  = flush ? 1'b0 : (stall_eff ? m_idv : 1'b1);
      n_idpc = (flush || stall_eff) ? m_idpc : m_pc;
      n_epc  = exct ? m_ex.a : m_epc;
      s = blank();
      s.v = m_idv; s.a = m_idpc;
      if (m_idv) begin
        s.alu = dec_alu_op; s.src = dec_alu_src; s.dst = dec_dst_sel; s.br = dec_branch;
        s.rd = dec_mem_rd; s.wr = dec_mem_wr; s.m2r = dec_mem_to_reg; s.rw = dec_reg_wr;
      end
      if (flush) begin
        n_ex = s; n_ex.v = 0; n_ex.rd = 0; n_ex.wr = 0; n_ex.rw = 0; n_ex.known = 0;
      end else if (stall_eff) n_ex = blank();
      else n_ex = s;
      n_mem = m_ex;
      if (flush) begin
        n_mem.v = 0; n_mem.rd = 0; n_mem.wr = 0; n_mem.rw = 0; n_mem.known = 0;
      end
      n_wb = m_mem;

      @(posedge clk);
      #1;
      m_pc = n_pc; m_idv = n_idv; m_idpc = n_idpc; m_epc = n_epc;
      m_ex = n_ex; m_mem = n_mem; m_wb = n_wb;
    end
    @(negedge clk);
    // final cycle comparison, redirect checks folded under R6/R7
    chk("R6", "pc", pc, m_pc);
    chk("R7", "epc", epc, m_epc);
    compare_stages("R2", "R3", "R3");
    $display("info: exception and branch together in %0d cycles", n_both);
    finish_run();
  end
endmodule